// File: doc/BRIEF.md
# Page-Buffered Serial Flash Command Sequencer

This block is a host-side master that turns one user request into a complete page-level operation on a serial flash with an on-chip page buffer. A request carries an operation kind, a 9-bit page number and a 9-bit start byte. The sequencer drops chip select and shifts out an opcode and a 24-bit address, MSB first. For a program request it then streams payload bytes taken from a valid/ready input. It raises chip select to launch the operation inside the flash, then reads the flash status register again and again until the ready bit shows.

When the flash reports ready, the block gives a one-cycle completion pulse. With that pulse it returns the status comparison bit, which is meaningful for a compare request. If ready is not seen within a fixed number of status reads, the completion pulse carries a timeout flag instead. The serial clock comes from a plain divider of the system clock and uses mode 0: the clock idles low, the flash samples on the rising edge, and the outputs change on the falling edge.

Payload back-pressure rules: `wr_ready` is high only in the data phase of a program request, when the serial engine is idle. A byte moves on any cycle where both `wr_valid` and `wr_ready` are high. A holder of data may keep `wr_valid` high for as long as it likes. The byte with `wr_last` set ends the data phase. The flash wraps its buffer pointer itself, so any number of bytes is allowed.

Top module: `flash_cmd_seq`

## Requirements
- R1: `cmd_kind` selects the opcode sent first: 0 sends 53h (page to buffer), 1 sends 60h (compare), 2 sends 58h (rewrite), 3 sends 82h (program through buffer).
- R2: Three address bytes follow the opcode. Together they carry 24 bits: six zero bits, then the 9 page bits, then 9 byte bits. The byte bits are `cmd_byte` for kind 3 and zero for every other kind.
- R3: Every byte goes out MSB first in mode 0. SCK idles low, and `spi_mosi` does not change while SCK is high.
- R4: `spi_cs_n` stays low through every rising SCK edge of a frame. SCK never toggles while `spi_cs_n` is high. `spi_cs_n` rises right after the final bit of the command, so a non-program frame holds exactly 32 bits.
- R5: Program payload bytes are taken only on `wr_valid && wr_ready`, in order, and they follow the address in the same frame. `wr_ready` is never high outside the data phase of a program request. Stalls on `wr_valid` do not change the bytes that are sent.
- R6: After the command frame, each status poll is its own frame of 57h followed by 8 clocks that sample `spi_miso`. Polling repeats until status bit 7 reads 1.
- R7: `done` pulses for one cycle when ready is seen, and `cmp_result` carries bit 6 of that last status byte.
- R8: If POLL_LIMIT status reads all show busy, `done` pulses with `timeout` high and no more polls are made.
- R9: `cmd_ready` is high only when the block is idle. A request presented while the block is busy is not taken.
- R10: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `done` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Sequencer idle, request taken |
| cmd_kind | input | 2 | 0 transfer, 1 compare, 2 rewrite, 3 program |
| cmd_page | input | 9 | Target page |
| cmd_byte | input | 9 | Start byte in buffer (program only) |
| wr_valid | input | 1 | Payload byte present |
| wr_ready | output | 1 | Payload byte taken |
| wr_data | input | 8 | Payload byte |
| wr_last | input | 1 | Marks the final payload byte |
| done | output | 1 | One-cycle completion pulse |
| cmp_result | output | 1 | Status bit 6 at completion |
| timeout | output | 1 | Set with done when ready never showed |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A bench flash model captures every frame and answers status reads with a set number of busy replies. Each of the four operation kinds is issued with distinct page and byte values. These tests show whether the opcode is right and whether the byte field is masked for the non-program kinds. Program requests are sent once with a steady payload and once with stalled payload. This shows that the byte order and the exact frame length do not depend on back-pressure. The busy-count settings tell apart a ready on the first poll, a ready after several busy polls, and a flash that never becomes ready (the timeout case). The compare-bit setting shows that the returned bit follows the status byte.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    K_XFER = 2'd0,
    K_CMP  = 2'd1,
    K_REWR = 2'd2,
    K_PROG = 2'd3
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_DATA,
    S_GAP,
    S_POLL,
    S_CHECK
  } state_t;

  localparam logic [7:0] OP_STATUS = 8'h57;

  function automatic logic [7:0] opcode_of(kind_t k);
    case (k)
      K_XFER:  return 8'h53;
      K_CMP:   return 8'h60;
      K_REWR:  return 8'h58;
      default: return 8'h82;
    endcase
  endfunction
endpackage

// File: rtl/fcs_tick.sv
module fcs_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!en || cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/fcs_shift.sv
module fcs_shift #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi
);
  logic       active;
  logic       tick;
  logic [7:0] sh;
  logic [2:0] bitn;

  fcs_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (active),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck    <= 1'b0;
      sh     <= '0;
      rx     <= '0;
      bitn   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sh     <= tx;
        bitn   <= '0;
        sck    <= 1'b0;
      end else if (active && tick) begin
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn + 1'b1;
          end
        end
      end
    end
  end

  assign busy = active;
  assign mosi = sh[7];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int SCK_DIV    = 2,
  parameter int GAP_CYC    = 4,
  parameter int POLL_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_kind,
  input  logic [8:0] cmd_page,
  input  logic [8:0] cmd_byte,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  output logic       done,
  output logic       cmp_result,
  output logic       timeout,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  import fcs_pkg::*;

  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [PW-1:0] PLIM  = PW'(POLL_LIMIT);
  localparam logic [GW-1:0] GLAST = GW'(GAP_CYC - 1);

  state_t        state;
  kind_t         kind_q;
  logic [8:0]    page_q, byte_q;
  logic [1:0]    idx;
  logic          launched, last_q;
  logic [PW-1:0] polls;
  logic [GW-1:0] gap_cnt;
  logic [7:0]    status_q;
  logic          cs_n_q, done_q, cmp_q, tmo_q;

  logic          sh_start, sh_busy, sh_done;
  logic [7:0]    sh_tx, sh_rx;
  logic [23:0]   addr;

  assign addr = {6'b0, page_q, (kind_q == K_PROG) ? byte_q : 9'd0};

  always_comb begin
    sh_start = 1'b0;
    sh_tx    = 8'h00;
    wr_ready = 1'b0;
    case (state)
      S_SEND: begin
        sh_start = !launched && !sh_busy;
        case (idx)
          2'd0:    sh_tx = opcode_of(kind_q);
          2'd1:    sh_tx = addr[23:16];
          2'd2:    sh_tx = addr[15:8];
          default: sh_tx = addr[7:0];
        endcase
      end
      S_DATA: begin
        wr_ready = !launched && !sh_busy;
        sh_start = wr_ready && wr_valid;
        sh_tx    = wr_data;
      end
      S_POLL: begin
        sh_start = !launched && !sh_busy;
        sh_tx    = (idx == 2'd0) ? OP_STATUS : 8'h00;
      end
      default: ;
    endcase
  end

  fcs_shift #(.DIV(SCK_DIV)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .start(sh_start),
    .tx   (sh_tx),
    .miso (spi_miso),
    .busy (sh_busy),
    .done (sh_done),
    .rx   (sh_rx),
    .sck  (spi_sck),
    .mosi (spi_mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind_q   <= K_XFER;
      page_q   <= '0;
      byte_q   <= '0;
      idx      <= '0;
      launched <= 1'b0;
      last_q   <= 1'b0;
      polls    <= '0;
      gap_cnt  <= '0;
      status_q <= '0;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      cmp_q    <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      if (sh_start) launched <= 1'b1;
      if (sh_done)  launched <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          kind_q <= kind_t'(cmd_kind);
          page_q <= cmd_page;
          byte_q <= cmd_byte;
          idx    <= '0;
          polls  <= '0;
          cs_n_q <= 1'b0;
          state  <= S_SEND;
        end
        S_SEND: if (sh_done) begin
          if (idx == 2'd3) begin
            if (kind_q == K_PROG) state <= S_DATA;
            else begin
              cs_n_q  <= 1'b1;
              gap_cnt <= '0;
              state   <= S_GAP;
            end
          end else idx <= idx + 1'b1;
        end
        S_DATA: begin
          if (sh_start) last_q <= wr_last;
          if (sh_done && last_q) begin
            cs_n_q  <= 1'b1;
            gap_cnt <= '0;
            state   <= S_GAP;
          end
        end
        S_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GLAST) begin
            cs_n_q <= 1'b0;
            idx    <= '0;
            state  <= S_POLL;
          end
        end
        S_POLL: if (sh_done) begin
          if (idx == 2'd0) idx <= 2'd1;
          else begin
            cs_n_q   <= 1'b1;
            status_q <= sh_rx;
            polls    <= polls + 1'b1;
            state    <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (status_q[7]) begin
            done_q <= 1'b1;
            cmp_q  <= status_q[6];
            state  <= S_IDLE;
          end else if (polls == PLIM) begin
            done_q <= 1'b1;
            tmo_q  <= 1'b1;
            state  <= S_IDLE;
          end else begin
            gap_cnt <= '0;
            state   <= S_GAP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state == S_IDLE);
  assign spi_cs_n   = cs_n_q;
  assign done       = done_q;
  assign cmp_result = cmp_q;
  assign timeout    = tmo_q;
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic wr_ready,
  input logic done,
  input logic timeout,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi
);
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R9
  accept_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && !cmd_ready));

  // R8
  timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);
endmodule

bind flash_cmd_seq fcs_chk u_fcs_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .wr_ready (wr_ready),
  .done     (done),
  .timeout  (timeout),
  .spi_sck  (spi_sck),
  .spi_cs_n (spi_cs_n),
  .spi_mosi (spi_mosi)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = '0;
  logic [8:0] cmd_page = '0, cmd_byte = '0;
  logic wr_valid = 1'b0, wr_last = 1'b0;
  logic [7:0] wr_data = '0;
  logic cmd_ready, wr_ready, done, cmp_result, timeout;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.SCK_DIV(2), .GAP_CYC(4), .POLL_LIMIT(LIMIT)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_page(cmd_page), .cmd_byte(cmd_byte),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .done(done), .cmp_result(cmp_result), .timeout(timeout),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash model
  logic [7:0] shreg = '0;
  logic [7:0] cur [0:15];
  logic [7:0] cap [0:15];
  int bitcnt = 0, fr_bits = 0, frames = 0, status_reads = 0, busy_left = 0;
  int sck_bad = 0, wr_seen = 0;
  logic cmp_flag = 1'b0;
  logic [7:0] stat;
  assign stat = {busy_left == 0, cmp_flag, 6'b0};

  always @(negedge spi_cs_n) begin bitcnt = 0; spi_miso = 1'b0; end
  always @(posedge spi_sck) begin
    if (spi_cs_n) sck_bad++;
    else begin
      shreg = {shreg[6:0], spi_mosi};
      bitcnt++;
      if (bitcnt % 8 == 0 && bitcnt / 8 <= 16) cur[bitcnt/8-1] = shreg;
    end
  end
  always @(negedge spi_sck)
    if (!spi_cs_n && bitcnt >= 8 && bitcnt < 16 && cur[0] == 8'h57) spi_miso = stat[15-bitcnt];
  always @(posedge spi_cs_n)
    if (rst_n && bitcnt > 0) begin
      if (cur[0] == 8'h57 && bitcnt == 16) begin
        status_reads++;
        if (busy_left > 0) busy_left--;
      end else begin
        frames++;
        fr_bits = bitcnt;
        for (int i = 0; i < 16; i++) cap[i] = cur[i];
      end
    end
  always @(negedge clk) if (wr_ready && cmd_kind != 2'd3) wr_seen++;

  always @(posedge clk) cycles++;
  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] k, logic [8:0] pg, logic [8:0] by);
    @(negedge clk);
    cmd_kind = k; cmd_page = pg; cmd_byte = by; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output logic c, output logic t);
    c = 1'b0; t = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin c = cmp_result; t = timeout; break; end
    end
  endtask

  task automatic feed(int n, int stall);
    for (int i = 0; i < n; i++) begin
      for (int s = 0; s < stall; s++) @(negedge clk);
      wr_valid = 1'b1; wr_data = 8'hA0 + 8'(i); wr_last = (i == n-1);
      do @(posedge clk); while (!wr_ready);
      @(negedge clk);
      wr_valid = 1'b0; wr_last = 1'b0;
    end
  endtask

  task automatic check_addr(string req, logic [8:0] pg, logic [8:0] by);
    logic [23:0] a = {6'b0, pg, by};
    chk(req, cap[1], a[23:16]);
    chk(req, cap[2], a[15:8]);
    chk(req, cap[3], a[7:0]);
  endtask

  task automatic run_plain(logic [1:0] k, logic [7:0] op, logic [8:0] pg, int busy, logic cf);
    logic c, t;
    int f0 = frames;
    busy_left = busy; cmp_flag = cf; status_reads = 0;
    issue(k, pg, 9'h1FF);
    wait_done(c, t);
    chk("R1 opcode", cap[0], op);
    check_addr("R2 addr byte-field zero", pg, 9'd0);
    chk("R4 frame bits", fr_bits, 32);
    chk("R6 poll count", status_reads, busy + 1);
    chk("R7 cmp bit", c, cf);
    chk("R8 no timeout", t, 0);
    chk("R4 one command frame", frames - f0, 1);
  endtask

  task automatic test_reset();
    chk("R10 cs_n", spi_cs_n, 1);
    chk("R10 sck", spi_sck, 0);
    chk("R10 done", done, 0);
    chk("R10 cmd_ready", cmd_ready, 1);
  endtask

  task automatic test_program(int n, int stall, logic [8:0] pg, logic [8:0] by);
    logic c, t;
    busy_left = 1; status_reads = 0;
    fork
      issue(2'd3, pg, by);
      feed(n, stall);
    join
    wait_done(c, t);
    chk("R1 program opcode", cap[0], 8'h82);
    check_addr("R2 program addr", pg, by);
    chk("R5 payload bits", fr_bits, 32 + 8*n);
    for (int i = 0; i < n; i++) chk("R5 payload byte", cap[4+i], 8'hA0 + 8'(i));
    chk("R6 program polls", status_reads, 2);
  endtask

  task automatic test_timeout();
    logic c, t;
    busy_left = 1000; status_reads = 0;
    issue(2'd1, 9'h0F0, 9'd0);
    wait_done(c, t);
    chk("R8 timeout flag", t, 1);
    repeat (200) @(negedge clk);
    chk("R8 polls stop at limit", status_reads, LIMIT);
    busy_left = 0;
  endtask

  task automatic test_busy_reject();
    logic c, t;
    int f0 = frames;
    busy_left = 0; wr_seen = 0;
    wr_valid = 1'b1;
    issue(2'd0, 9'h033, 9'd0);
    chk("R9 not ready while busy", cmd_ready, 0);
    @(negedge clk);
    cmd_kind = 2'd1; cmd_page = 9'h155; cmd_valid = 1'b1;
    repeat (20) @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 2'd0;
    wait_done(c, t);
    wr_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 busy request dropped", frames - f0, 1);
    chk("R9 page kept", cap[2][7:1], 7'h33 >> 0 & 7'h7F);
    chk("R5 no wr_ready outside program", wr_seen, 0);
    chk("R4 sck only with cs low", sck_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_plain(2'd0, 8'h53, 9'h1A5, 0, 1'b0);
    run_plain(2'd1, 8'h60, 9'h0C3, 2, 1'b1);
    run_plain(2'd1, 8'h60, 9'h100, 1, 1'b0);
    run_plain(2'd2, 8'h58, 9'h07E, 3, 1'b0);
    test_program(3, 0, 9'h12D, 9'h107);
    test_program(4, 5, 9'h001, 9'h0FF);
    test_timeout();
    test_busy_reject();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule